// File: doc/BRIEF.md
# Escape-Mode Low-Power Data Transmitter

This block drives the two single-ended lines of one serial data lane through the low-power escape handshake in order to send a short burst of data. While a transfer is in progress it takes over the lane and sets each line level directly. Once the burst has been sent, it hands the lane back to the normal lane controller.

A host sets up a transfer in one step. It places a byte count, a per-state hold time and a line-swap flag on the inputs and pulses start. The block then sends the following, in order:

1. the escape entry pattern;
2. the low-power data command byte;
3. each payload byte, which it pulls through a valid/ready byte port;
4. the exit pattern.

Each bit goes out as a mark state followed by a space state, least significant bit first. Every line state is held for the programmed number of clock cycles.

Top module: `lpdt_esc_tx`

## Requirements
- R1: After reset and whenever no transfer is active, `ovr_en_o`, `busy_o`, `done_o` and `byte_ready_o` are low, and both lines read high (`dp_o`=1, `dn_o`=1).
- R2: A `start_i` seen while idle captures `count_i`, `hold_i` and `swap_i`. From the next cycle, `busy_o` and `ovr_en_o` are high. A `start_i` seen while busy has no effect, and later changes to the three inputs do not affect the running transfer.
- R3: The transfer opens with five line states, written as {dp,dn}: 11, 10, 00, 01, 00.
- R4: The command byte 0x87 follows the opening pattern. It is sent LSB first. A 1 bit is the mark {dp,dn}=10, a 0 bit is the mark 01, and every mark is followed by the space 00.
- R5: Exactly `count_i` payload bytes follow the command byte, in the order they are accepted. Each is encoded as in R4.
- R6: `byte_ready_o` rises in the last cycle of the final space of the preceding byte when bytes remain, or stays high while waiting. A byte is taken on a clock edge where valid and ready are both high. While the block waits, the lines stay at 00, which extends that space by the waiting cycles.
- R7: With a count of zero, the command byte is sent and the exit pattern follows directly.
- R8: The transfer closes with 00, 10, 11. In the next cycle `ovr_en_o` and `busy_o` are low and `done_o` is high for exactly one cycle.
- R9: Every line state lasts exactly the captured hold count in cycles (minimum 1), apart from the wait extension in R6. Adjacent identical states therefore appear as one longer run.
- R10: With the captured swap flag set, states 10 and 01 exchange their dp and dn values. States 00 and 11 are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| count_i | input | CNT_W | Number of payload bytes |
| hold_i | input | HOLD_W | Cycles per line state, at least 1 |
| swap_i | input | 1 | Exchange dp/dn for the 10 and 01 states |
| byte_valid_i | input | 1 | Payload byte offered |
| byte_data_i | input | 8 | Payload byte |
| byte_ready_o | output | 1 | Payload byte taken on this edge when valid |
| ovr_en_o | output | 1 | Lane override active |
| dp_o | output | 1 | Positive line level |
| dn_o | output | 1 | Negative line level |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the override is released |

## Verification
The bench compresses the line levels into runs of (state, length) and compares them with a run list it builds arithmetically. Because of this, a corrupted step index, bit counter or shift register shows up as a wrong state or wrong run length within one hold period of the fault. A hold counter that reloads wrongly changes the next run length. A byte counter that is off by one adds or drops sixteen runs before the closing pattern, or hangs the handshake until the watchdog fires. A swap flag that is not latched at start flips the mark states in the run where the input changes.

// File: rtl/lpdt_pkg.sv
package lpdt_pkg;
  // line state encoding: bit1 = dp, bit0 = dn
  typedef enum logic [1:0] {
    LN_00 = 2'b00,
    LN_01 = 2'b01,
    LN_10 = 2'b10,
    LN_11 = 2'b11
  } line_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ENTRY,
    SQ_BYTE,
    SQ_FETCH,
    SQ_EXIT
  } seq_e;

  localparam logic [7:0] LPDT_CMD   = 8'h87;
  localparam logic [2:0] ENTRY_LAST = 3'd4;
  localparam logic [2:0] EXIT_LAST  = 3'd2;

  function automatic line_e mark_of(input logic b);
    return b ? LN_10 : LN_01;
  endfunction
endpackage

// File: rtl/lpdt_hold_timer.sv
module lpdt_hold_timer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_ld_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              restart_i,
  output logic              expire_o
);
  localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

  logic [HOLD_W-1:0] hold_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      cnt_q  <= '0;
    end else if (cfg_ld_i) begin
      hold_q <= hold_i;
      cnt_q  <= hold_i - ONE;
    end else if (restart_i) begin
      cnt_q <= hold_q - ONE;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign expire_o = (cnt_q == '0);

  // R9
  hold_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && hold_q > ONE) |=> !expire_o);
endmodule

// File: rtl/lpdt_seq.sv
module lpdt_seq
  import lpdt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             swap_i,
  input  logic             expire_i,
  input  logic             valid_i,
  input  logic [7:0]       data_i,
  output logic             cfg_ld_o,
  output logic             restart_o,
  output logic             ready_o,
  output line_e            line_o,
  output logic             swap_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seq_e             st_q, st_d;
  logic [2:0]       idx_q, idx_d, bit_q, bit_d;
  logic             space_q, space_d, swap_q, swap_d, done_q, done_d;
  logic [7:0]       sh_q, sh_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             byte_end, take;

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    bit_d     = bit_q;
    space_d   = space_q;
    sh_d      = sh_q;
    rem_d     = rem_q;
    swap_d    = swap_q;
    done_d    = 1'b0;
    cfg_ld_o  = 1'b0;
    restart_o = 1'b0;
    byte_end  = (st_q == SQ_BYTE) && space_q && (bit_q == 3'd7) && expire_i;
    ready_o   = (byte_end && rem_q != '0) || (st_q == SQ_FETCH);
    take      = ready_o && valid_i;
    unique case (st_q)
      SQ_IDLE: if (start_i) begin
        st_d     = SQ_ENTRY;
        idx_d    = '0;
        rem_d    = count_i;
        swap_d   = swap_i;
        cfg_ld_o = 1'b1;
      end
      SQ_ENTRY: if (expire_i) begin
        restart_o = 1'b1;
        if (idx_q == ENTRY_LAST) begin
          st_d    = SQ_BYTE;
          sh_d    = LPDT_CMD;
          bit_d   = '0;
          space_d = 1'b0;
        end else idx_d = idx_q + 3'd1;
      end
      SQ_BYTE: if (expire_i) begin
        if (!space_q) begin
          space_d   = 1'b1;
          restart_o = 1'b1;
        end else if (bit_q != 3'd7) begin
          space_d   = 1'b0;
          bit_d     = bit_q + 3'd1;
          sh_d      = sh_q >> 1;
          restart_o = 1'b1;
        end else if (rem_q == '0) begin
          st_d      = SQ_EXIT;
          idx_d     = '0;
          restart_o = 1'b1;
        end else if (!take) begin
          st_d = SQ_FETCH;
        end
      end
      SQ_FETCH: ;
      SQ_EXIT: if (expire_i) begin
        if (idx_q == EXIT_LAST) begin
          st_d   = SQ_IDLE;
          done_d = 1'b1;
        end else begin
          idx_d     = idx_q + 3'd1;
          restart_o = 1'b1;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
    // payload byte accepted: start its first mark
    if (take) begin
      st_d      = SQ_BYTE;
      sh_d      = data_i;
      bit_d     = '0;
      space_d   = 1'b0;
      rem_d     = rem_q - CNT_ONE;
      restart_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      idx_q   <= '0;
      bit_q   <= '0;
      space_q <= 1'b0;
      sh_q    <= '0;
      rem_q   <= '0;
      swap_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      bit_q   <= bit_d;
      space_q <= space_d;
      sh_q    <= sh_d;
      rem_q   <= rem_d;
      swap_q  <= swap_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    unique case (st_q)
      SQ_ENTRY: case (idx_q)
        3'd0:    line_o = LN_11;
        3'd1:    line_o = LN_10;
        3'd3:    line_o = LN_01;
        default: line_o = LN_00;
      endcase
      SQ_BYTE:  line_o = space_q ? LN_00 : mark_of(sh_q[0]);
      SQ_FETCH: line_o = LN_00;
      SQ_EXIT: case (idx_q)
        3'd0:    line_o = LN_00;
        3'd1:    line_o = LN_10;
        default: line_o = LN_11;
      endcase
      default:  line_o = LN_11;
    endcase
  end

  assign swap_o = swap_q;
  assign busy_o = (st_q != SQ_IDLE);
  assign done_o = done_q;

  // R6
  fetch_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SQ_FETCH && !valid_i) |=> st_q == SQ_FETCH);
endmodule

// File: rtl/lpdt_line_map.sv
module lpdt_line_map
  import lpdt_pkg::*;
(
  input  line_e st_i,
  input  logic  swap_i,
  input  logic  ovr_i,
  output logic  dp_o,
  output logic  dn_o
);
  // exchanging the two bits leaves 00 and 11 unchanged
  always_comb begin
    if (!ovr_i)      {dp_o, dn_o} = 2'b11;
    else if (swap_i) {dp_o, dn_o} = {st_i[0], st_i[1]};
    else             {dp_o, dn_o} = {st_i[1], st_i[0]};
  end
endmodule

// File: rtl/lpdt_esc_tx.sv
module lpdt_esc_tx
  import lpdt_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic              swap_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_data_i,
  output logic              byte_ready_o,
  output logic              ovr_en_o,
  output logic              dp_o,
  output logic              dn_o,
  output logic              busy_o,
  output logic              done_o
);
  logic  cfg_ld, restart, expire, swap_q;
  line_e line;

  lpdt_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_ld_i (cfg_ld),
    .hold_i   (hold_i),
    .restart_i(restart),
    .expire_o (expire)
  );

  lpdt_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .count_i  (count_i),
    .swap_i   (swap_i),
    .expire_i (expire),
    .valid_i  (byte_valid_i),
    .data_i   (byte_data_i),
    .cfg_ld_o (cfg_ld),
    .restart_o(restart),
    .ready_o  (byte_ready_o),
    .line_o   (line),
    .swap_o   (swap_q),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  assign ovr_en_o = busy_o;

  lpdt_line_map u_map (
    .st_i  (line),
    .swap_i(swap_q),
    .ovr_i (ovr_en_o),
    .dp_o  (dp_o),
    .dn_o  (dn_o)
  );

  // R2
  start_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o && ovr_en_o && dp_o && dn_o);
  // R9
  hold_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |-> hold_i != '0);
  // R6
  ready_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> busy_o && !dp_o && !dn_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !ovr_en_o && $past(busy_o));
endmodule

// File: tb/lpdt_esc_tx_bench.sv
`timescale 1ns/1ps
module lpdt_esc_tx_bench;
  localparam int CNT_W  = 4;
  localparam int HOLD_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [CNT_W-1:0]  count_i = '0;
  logic [HOLD_W-1:0] hold_i = 8'd1;
  logic              swap_i = 1'b0;
  logic              byte_valid_i = 1'b0;
  logic [7:0]        byte_data_i = '0;
  logic              byte_ready_o, ovr_en_o, dp_o, dn_o, busy_o, done_o;

  always #2.5 clk_i = ~clk_i;

  lpdt_esc_tx #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_lpdt_esc_tx (.*);

  int checks = 0;
  int fails  = 0;

  logic [1:0] exp_st [256];
  int         exp_dur[256];
  string      exp_tag[256];
  int         exp_n;
  logic [1:0] obs_st [256];
  int         obs_dur[256];
  int         obs_n;
  int         ready_bad, done_cnt, done_bad;
  logic       prev_busy = 1'b0;
  logic [7:0] pay[16];
  int         dly[16];
  logic       cur_sw;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [1:0] sw_map(input logic [1:0] s);
    return cur_sw ? {s[0], s[1]} : s;
  endfunction

  task automatic push(input logic [1:0] s, input int d, input string tag);
    logic [1:0] m = sw_map(s);
    if (exp_n > 0 && exp_st[exp_n-1] == m) exp_dur[exp_n-1] += d;
    else begin
      exp_st[exp_n] = m; exp_dur[exp_n] = d; exp_tag[exp_n] = tag; exp_n++;
    end
  endtask

  task automatic push_byte(input logic [7:0] b, input int h, input int ext, input string tag);
    for (int i = 0; i < 8; i++) begin
      push(b[i] ? 2'b10 : 2'b01, h, tag);
      push(2'b00, h + ((i == 7) ? ext : 0), tag);
    end
  endtask

  // monitor: run-length compress the lines while the override is active
  initial begin
    forever begin
      @(negedge clk_i);
      if (ovr_en_o) begin
        if (obs_n > 0 && obs_st[obs_n-1] == {dp_o, dn_o}) obs_dur[obs_n-1]++;
        else if (obs_n < 256) begin
          obs_st[obs_n] = {dp_o, dn_o}; obs_dur[obs_n] = 1; obs_n++;
        end
      end
      if (byte_ready_o && (dp_o || dn_o || !busy_o)) ready_bad++;
      if (done_o) begin
        done_cnt++;
        if (busy_o || ovr_en_o || !prev_busy) done_bad++;
      end
      prev_busy = busy_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL R8 watchdog: actual no completion expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic run(input int h, input bit sw, input int n, input int r, input bit hijack);
    string ptag;
    exp_n = 0; cur_sw = sw;
    ptag = sw ? "R5 R9 R10" : "R5 R9";
    for (int j = 0; j < n; j++) begin
      pay[j] = 8'((r * 37 + j * 91 + 13) & 255);
      if (r == 7) pay[j] = (j == 0) ? 8'hFF : 8'h00;
      dly[j] = (r + j) % 3 + ((j == 1) ? 2 : 0);
    end
    // R3 opening pattern
    push(2'b11, h, "R3"); push(2'b10, h, "R3"); push(2'b00, h, "R3");
    push(2'b01, h, "R3"); push(2'b00, h, "R3");
    // R4 command byte
    push_byte(8'h87, h, (n > 0) ? dly[0] : 0, (n == 0) ? "R4 R7" : "R4");
    for (int j = 0; j < n; j++)
      push_byte(pay[j], h, (j + 1 < n) ? dly[j+1] : 0, ptag);
    // R8 closing pattern
    push(2'b00, h, "R8"); push(2'b10, h, "R8"); push(2'b11, h, "R8");

    obs_n = 0; ready_bad = 0; done_cnt = 0; done_bad = 0;
    @(negedge clk_i);
    hold_i = 8'(h); swap_i = sw; count_i = CNT_W'(n); start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o && ovr_en_o, "R2", "busy after start", int'(busy_o), 1);
    if (hijack) begin
      hold_i = 8'(h + 2); swap_i = !sw; count_i = CNT_W'(n + 1); start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    fork
      begin
        for (int j = 0; j < n; j++) begin
          if (dly[j] > 0) begin
            while (!byte_ready_o) @(negedge clk_i);
            repeat (dly[j]) @(negedge clk_i);
          end
          byte_data_i = pay[j]; byte_valid_i = 1'b1;
          while (!byte_ready_o) @(negedge clk_i);
          @(posedge clk_i); #1;
          byte_valid_i = 1'b0;
        end
      end
      wait (done_cnt > 0);
    join
    @(negedge clk_i);
    check(obs_n == exp_n, (n == 0) ? "R7" : (hijack ? "R2" : "R5"), "state run count", obs_n, exp_n);
    for (int i = 0; i < exp_n && i < obs_n; i++) begin
      check(obs_st[i] == exp_st[i], exp_tag[i], $sformatf("run %0d state", i),
            int'(obs_st[i]), int'(exp_st[i]));
      check(obs_dur[i] == exp_dur[i], exp_tag[i], $sformatf("run %0d length", i),
            obs_dur[i], exp_dur[i]);
    end
    check(ready_bad == 0, "R6", "ready outside space", ready_bad, 0);
    check(done_cnt == 1 && done_bad == 0, "R8", "done pulse", done_cnt, 1);
    check(!ovr_en_o && !busy_o && !done_o && dp_o && dn_o, "R1", "idle after release",
          int'({ovr_en_o, busy_o, done_o, dp_o, dn_o}), 3);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(!ovr_en_o && !busy_o && !done_o && !byte_ready_o && dp_o && dn_o, "R1",
          "reset outputs", int'({ovr_en_o, busy_o, done_o, byte_ready_o, dp_o, dn_o}), 3);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!ovr_en_o && !busy_o && dp_o && dn_o, "R1", "idle after reset",
          int'({ovr_en_o, busy_o, dp_o, dn_o}), 3);
    begin
      int r = 0;
      for (int h = 1; h <= 3; h++)
        for (int sw = 0; sw < 2; sw++)
          for (int n = 0; n <= 2; n++) begin
            run(h, sw[0], n, r, 1'b0);
            r++;
          end
    end
    run(2, 1'b0, 3, 7, 1'b0);
    run(1, 1'b1, 2, 5, 1'b1);
    run(3, 1'b0, 0, 9, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule